// File: doc/BRIEF.md
# Indexed-Window Interrupt Redirection Controller

This block routes a set of interrupt input lines (24 by default) to a single delivery channel. Software sees only two bus locations: an index register that selects an internal register, and a data window that reads or writes the selected register. Three identification registers and one 64-bit routing entry for each input line sit behind the window. Each routing entry is split into a low word and a high word.

Each input line is registered once. It is then corrected for polarity and treated as either edge-sensitive or level-sensitive, as its entry selects. A line that is active and not masked raises a request. The lowest-numbered requesting line wins and its request is loaded into a delivery register. That register holds the vector, delivery mode, destination mode and destination until the consumer accepts it with a valid/ready handshake. A level-sensitive line that has been delivered is held off by its remote-IRR flag. The flag clears when an end-of-interrupt with the same vector arrives.

Top module: `irq_route_ctrl`

## Requirements
- R1: A bus write at byte offset 0x00 loads the 8-bit index (read back there in bits 7:0). Accesses at offset 0x10 read or write the register the current index selects, and any number of them may follow one index write.
- R2: Register 0 holds a writable 4-bit controller ID in bits 27:24 that resets to 0. All its other bits read zero.
- R3: Register 1 reads the version parameter in bits 7:0 and NUM_PINS-1 in bits 23:16. Register 2 reads the arbitration ID parameter in bits 27:24. All other bits of both read zero.
- R4: The entry for line n is at index 0x10+2n (low word) and 0x11+2n (high word). The low word holds vector 7:0, delivery mode 10:8, destination mode 11 (1 logical), delivery status 12, polarity 13 (1 active low), remote IRR 14, trigger 15 (1 level) and mask 16 (1 blocked). The high word holds the destination in 31:24. After reset the low word reads 0x00010000 and the high word reads 0.
- R5: Writes to bits 12 and 14 of a low word are ignored, and unused bits read zero. Writing 0xFFFFFFFF to an idle entry's low word reads back 0x0001AFFF.
- R6: An edge-sensitive line delivers once per inactive-to-active transition after polarity correction. A line held active does not deliver again.
- R7: Delivering a level-sensitive line sets its remote IRR, which blocks further delivery. An end-of-interrupt with a different vector has no effect. One with the entry's vector clears the flag, and a line that is still active then delivers again.
- R8: A masked line never raises a request. An edge that arrives while the line is masked is discarded and is not delivered on unmask.
- R9: When several lines request at once, the lowest-numbered line is delivered first.
- R10: The delivery outputs stay valid and unchanged until dlv_ready is seen. Delivery status reads 1 while the line's request is waiting or held unaccepted, and 0 once it has been accepted.
- R11: In physical destination mode the delivered destination carries only bits 3:0 of the entry's field, with the upper bits zero. In logical mode all 8 bits pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 5 | Byte offset: 0x00 index, 0x10 data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed location |
| irq_in | input | NUM_PINS | Interrupt input lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Consumer accepts the request |
| dlv_vector | output | 8 | Delivered vector |
| dlv_mode | output | 3 | Delivered delivery mode |
| dlv_dstmode | output | 1 | Delivered destination mode (1 logical) |
| dlv_dest | output | 8 | Delivered destination |

## Verification
The bench targets edge lines held active, which a faulty edge detector would deliver over and over. It also raises an edge while the line is masked, then unmasks, which a design that latches masked edges would turn into a stray delivery. Level lines are retired with a wrong vector and then with the right one. A design with a loose IRR comparison would re-deliver too early, and one that never clears IRR would hang the line. Further cases check that a stalled handshake keeps its outputs stable, that simultaneous requests leave lowest-first, that all-ones writes leave the status bits untouched, and that physical mode trims the destination.

// File: rtl/irq_route_pkg.sv
// Shared types and constants for the interrupt redirection controller.
// Assumes at most 64 lines so every entry index fits in 8 bits.
package irq_route_pkg;

    // Software-writable part of one routing entry
    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       pol;
        logic       dstmode;
        logic [2:0] dmode;
        logic [7:0] vector;
    } rte_t;

    localparam logic [4:0] OFS_INDEX    = 5'h00;
    localparam logic [4:0] OFS_DATA     = 5'h10;
    localparam logic [7:0] IDX_ID       = 8'h00;
    localparam logic [7:0] IDX_VER      = 8'h01;
    localparam logic [7:0] IDX_ARB      = 8'h02;
    localparam logic [7:0] IDX_RTE_BASE = 8'h10;

    localparam rte_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                   dstmode: 1'b0, dmode: 3'b000, vector: 8'h00};

endpackage

// File: rtl/irq_route_regs.sv
// Index register, ID register and routing entry storage behind a data window.
// Assumes reads are combinational from the current index; writes take effect
// on the clock edge that sees bus_en and bus_we.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h11,
    parameter logic [3:0] ARB_ID   = 4'h0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [4:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PINS-1:0]       dstat,
    input  logic [NUM_PINS-1:0]       rirr,
    output rte_t [NUM_PINS-1:0]       rte
);
    localparam int         PIN_W   = $clog2(NUM_PINS);
    localparam logic [7:0] IDX_END = 8'(16 + 2 * NUM_PINS);

    logic [7:0]       index_q;
    logic [3:0]       id_q;
    logic             wr_index, wr_data, in_rte, hi_word;
    logic [7:0]       rte_off;
    logic [PIN_W-1:0] sel_pin;
    logic [31:0]      reg_rd;
    rte_t             cur;
    logic             unused_wbits;

    assign wr_index = bus_en && bus_we && (bus_addr == OFS_INDEX);
    assign wr_data  = bus_en && bus_we && (bus_addr == OFS_DATA);
    assign in_rte   = (index_q >= IDX_RTE_BASE) && (index_q < IDX_END);
    assign rte_off  = index_q - IDX_RTE_BASE;
    assign hi_word  = rte_off[0];
    assign sel_pin  = rte_off[PIN_W:1];
    assign cur      = rte[sel_pin];
    assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

    // Index register: chosen by the last write at offset 0x00
    always_ff @(posedge clk) begin
        if (!rst_n)        index_q <= 8'h00;
        else if (wr_index) index_q <= bus_wdata[7:0];
    end

    // Controller ID: only software-writable field of register 0
    always_ff @(posedge clk) begin
        if (!rst_n)                                id_q <= 4'h0;
        else if (wr_data && index_q == IDX_ID)     id_q <= bus_wdata[27:24];
    end

    // One storage element per routing entry
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_rte
        // Entry update: high word sets destination, low word the control fields
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rte[g] <= RTE_RESET;
            end else if (wr_data && in_rte && sel_pin == PIN_W'(g)) begin
                if (hi_word) begin
                    rte[g].dest <= bus_wdata[31:24];
                end else begin
                    rte[g].vector  <= bus_wdata[7:0];
                    rte[g].dmode   <= bus_wdata[10:8];
                    rte[g].dstmode <= bus_wdata[11];
                    rte[g].pol     <= bus_wdata[13];
                    rte[g].trig    <= bus_wdata[15];
                    rte[g].mask    <= bus_wdata[16];
                end
            end
        end
    end

    // Data window read mux
    always_comb begin
        reg_rd = '0;
        if (index_q == IDX_ID) begin
            reg_rd[27:24] = id_q;
        end else if (index_q == IDX_VER) begin
            reg_rd[7:0]   = VERSION;
            reg_rd[23:16] = 8'(NUM_PINS - 1);
        end else if (index_q == IDX_ARB) begin
            reg_rd[27:24] = ARB_ID;
        end else if (in_rte) begin
            if (hi_word) reg_rd[31:24] = cur.dest;
            else reg_rd[16:0] = {cur.mask, cur.trig, rirr[sel_pin], cur.pol,
                                 dstat[sel_pin], cur.dstmode, cur.dmode, cur.vector};
        end
    end

    // Bus read: index at 0x00, selected register at 0x10
    always_comb begin
        if (bus_addr == OFS_INDEX)     bus_rdata = {24'h0, index_q};
        else if (bus_addr == OFS_DATA) bus_rdata = reg_rd;
        else                           bus_rdata = '0;
    end

    // R2: the ID register changes only through a data write at index 0
    a_r2_id_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_data && index_q == IDX_ID) |=> $stable(id_q));

endmodule

// File: rtl/irq_route_pin.sv
// Per-line input conditioning: one sample stage, polarity correction,
// edge capture and level/remote-IRR handling. Assumes grant is one cycle
// wide and arrives only while req is high.
module irq_route_pin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_in,
    input  logic       pol,
    input  logic       trig,
    input  logic       mask,
    input  logic [7:0] vector,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    input  logic       grant,
    output logic       req,
    output logic       rirr
);
    logic samp_q, prev_q, pend_q, rirr_q;
    logic act, rise;

    assign act  = samp_q ^ pol;
    assign rise = act && !prev_q;

    // Input sample and previous active level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= irq_in;
            prev_q <= act;
        end
    end

    // Edge capture: masked or level lines hold nothing, a grant consumes it
    always_ff @(posedge clk) begin
        if (!rst_n)              pend_q <= 1'b0;
        else if (mask || trig)   pend_q <= 1'b0;
        else                     pend_q <= (pend_q && !grant) || rise;
    end

    // Remote IRR: set by delivery of a level line, cleared by matching EOI
    always_ff @(posedge clk) begin
        if (!rst_n)                                    rirr_q <= 1'b0;
        else if (grant && trig)                        rirr_q <= 1'b1;
        else if (eoi_valid && eoi_vector == vector)    rirr_q <= 1'b0;
    end

    assign req  = !mask && (trig ? (act && !rirr_q) : pend_q);
    assign rirr = rirr_q;

    // R6: a captured edge leaves once its grant is taken, unless a new edge came
    a_r6_edge_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !trig && !rise) |=> !pend_q);

endmodule

// File: rtl/irq_route_deliver.sv
// Lowest-number-first selection and the delivery holding register.
// Assumes the consumer may stall with dlv_ready low for any number of cycles.
module irq_route_deliver #(
    parameter int NUM_PINS = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       req,
    input  logic [NUM_PINS-1:0][7:0]  vec,
    input  logic [NUM_PINS-1:0][2:0]  mode,
    input  logic [NUM_PINS-1:0]       dstmode,
    input  logic [NUM_PINS-1:0][7:0]  dest,
    input  logic                      dlv_ready,
    output logic                      dlv_valid,
    output logic [7:0]                dlv_vector,
    output logic [2:0]                dlv_mode,
    output logic                      dlv_dstmode,
    output logic [7:0]                dlv_dest,
    output logic [NUM_PINS-1:0]       grant,
    output logic [NUM_PINS-1:0]       inflight
);
    localparam int PIN_W = $clog2(NUM_PINS);

    logic [PIN_W-1:0] sel, pin_q;
    logic             any_req, can_load, valid_q;
    logic [7:0]       vec_q, dest_q, sel_dest;
    logic [2:0]       mode_q;
    logic             dstmode_q;

    // Lowest-numbered requesting line
    always_comb begin
        sel = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req[i]) sel = PIN_W'(i);
        end
    end

    assign any_req  = |req;
    assign can_load = !valid_q || dlv_ready;
    assign grant    = (can_load && any_req) ? (NUM_PINS'(1) << sel) : '0;
    assign sel_dest = dstmode[sel] ? dest[sel] : {4'h0, dest[sel][3:0]};

    // Holding register: refills whenever empty or accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            pin_q     <= '0;
            vec_q     <= '0;
            mode_q    <= '0;
            dstmode_q <= 1'b0;
            dest_q    <= '0;
        end else if (can_load) begin
            valid_q <= any_req;
            if (any_req) begin
                pin_q     <= sel;
                vec_q     <= vec[sel];
                mode_q    <= mode[sel];
                dstmode_q <= dstmode[sel];
                dest_q    <= sel_dest;
            end
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_inflight
        assign inflight[g] = valid_q && (pin_q == PIN_W'(g));
    end

    assign dlv_valid   = valid_q;
    assign dlv_vector  = vec_q;
    assign dlv_mode    = mode_q;
    assign dlv_dstmode = dstmode_q;
    assign dlv_dest    = dest_q;

    // R10: an unaccepted request keeps its contents
    a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !dlv_ready) |=> (valid_q && $stable(vec_q) && $stable(dest_q)
                                     && $stable(mode_q) && $stable(pin_q)));

    // R9: no lower-numbered line is requesting when a grant is issued
    a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((req & (grant - NUM_PINS'(1))) == '0));

endmodule

// File: rtl/irq_route_ctrl.sv
// Top of the interrupt redirection controller: register window, one
// conditioning slice per input line, and the delivery stage.
// Assumes 2 <= NUM_PINS <= 64 and a single synchronous clock domain.
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h11,
    parameter logic [3:0] ARB_ID   = 4'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [4:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                dlv_valid,
    input  logic                dlv_ready,
    output logic [7:0]          dlv_vector,
    output logic [2:0]          dlv_mode,
    output logic                dlv_dstmode,
    output logic [7:0]          dlv_dest
);
    rte_t [NUM_PINS-1:0]      rte;
    logic [NUM_PINS-1:0]      req, grant, inflight, rirr, dstat;
    logic [NUM_PINS-1:0][7:0] vec_a, dest_a;
    logic [NUM_PINS-1:0][2:0] mode_a;
    logic [NUM_PINS-1:0]      dstmode_a;

    assign dstat = req | inflight;

    irq_route_regs #(
        .NUM_PINS (NUM_PINS),
        .VERSION  (VERSION),
        .ARB_ID   (ARB_ID)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dstat     (dstat),
        .rirr      (rirr),
        .rte       (rte)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign vec_a[g]     = rte[g].vector;
        assign mode_a[g]    = rte[g].dmode;
        assign dstmode_a[g] = rte[g].dstmode;
        assign dest_a[g]    = rte[g].dest;

        irq_route_pin u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq_in     (irq_in[g]),
            .pol        (rte[g].pol),
            .trig       (rte[g].trig),
            .mask       (rte[g].mask),
            .vector     (rte[g].vector),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .grant      (grant[g]),
            .req        (req[g]),
            .rirr       (rirr[g])
        );

        // R8: the selector never grants a masked line
        a_r8_no_masked_grant: assert property (@(posedge clk) disable iff (!rst_n)
            grant[g] |-> !rte[g].mask);

        // R7: a line waiting for its EOI is never granted
        a_r7_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
            rirr[g] |-> !grant[g]);

        // R7: granting a level line raises its remote IRR
        a_r7_irr_set: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[g] && rte[g].trig) |=> rirr[g]);
    end

    irq_route_deliver #(
        .NUM_PINS (NUM_PINS)
    ) u_deliver (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .vec         (vec_a),
        .mode        (mode_a),
        .dstmode     (dstmode_a),
        .dest        (dest_a),
        .dlv_ready   (dlv_ready),
        .dlv_valid   (dlv_valid),
        .dlv_vector  (dlv_vector),
        .dlv_mode    (dlv_mode),
        .dlv_dstmode (dlv_dstmode),
        .dlv_dest    (dlv_dest),
        .grant       (grant),
        .inflight    (inflight)
    );

endmodule

// File: tb/irq_route_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_route_ctrl_tb;
    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]    bus_addr = 5'h0;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_in = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = 8'h0;
    logic          dlv_valid, dlv_ready = 1'b0;
    logic [7:0]    dlv_vector, dlv_dest;
    logic [2:0]    dlv_mode;
    logic          dlv_dstmode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_route_ctrl #(.NUM_PINS(NP), .VERSION(8'h11), .ARB_ID(4'hA)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vector(dlv_vector),
        .dlv_mode(dlv_mode), .dlv_dstmode(dlv_dstmode), .dlv_dest(dlv_dest)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [31:0] d);
        bus_write(5'h00, {24'h0, idx});
        bus_write(5'h10, d);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [31:0] d);
        bus_write(5'h00, {24'h0, idx});
        bus_addr = 5'h10;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_valid(input string req);
        bit ok = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (dlv_valid) begin ok = 1'b1; break; end
        end
        check(req, {31'h0, ok}, 32'h1);
    endtask

    task automatic accept();
        @(negedge clk); dlv_ready = 1'b1;
        @(negedge clk); dlv_ready = 1'b0;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(8'h00, d); check("R2 id reset", d, 32'h0);
        rd_reg(8'h01, d); check("R3 version reg", d, 32'h0017_0011);
        rd_reg(8'h02, d); check("R3 arbitration reg", d, 32'h0A00_0000);
        rd_reg(8'h10, d); check("R4 pin0 low reset", d, 32'h0001_0000);
        rd_reg(8'h11 + 8'd46, d); check("R4 pin23 high reset", d, 32'h0);
        rd_reg(8'h10 + 8'd46, d); check("R4 pin23 low reset", d, 32'h0001_0000);
        check("R10 no request after reset", {31'h0, dlv_valid}, 32'h0);
    endtask

    task automatic t_window();
        logic [31:0] d;
        bus_write(5'h00, 32'h0);
        bus_write(5'h10, 32'hFFFF_FFFF);
        bus_addr = 5'h10; #1 d = bus_rdata;
        check("R2 id only bits 27:24", d, 32'h0F00_0000);
        bus_addr = 5'h00; #1 d = bus_rdata;
        check("R1 index readback", d, 32'h0);
        // R1: read-modify-write with a single index write
        bus_write(5'h00, 32'h10 + 32'd14);
        bus_addr = 5'h10; #1 d = bus_rdata;
        bus_write(5'h10, d | 32'h0000_00C4);
        bus_addr = 5'h10; #1 d = bus_rdata;
        check("R1 rmw through window", d, 32'h0001_00C4);
        bus_write(5'h10, 32'h0001_0000);
        wr_reg(8'h00, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr_reg(8'h10 + 8'd8, 32'hFFFF_FFFF);
        rd_reg(8'h10 + 8'd8, d);
        check("R5 read-only bits ignored", d, 32'h0001_AFFF);
        wr_reg(8'h10 + 8'd8, 32'h0001_0000);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr_reg(8'h11 + 8'd6, 32'h5A00_0000);
        wr_reg(8'h10 + 8'd6, 32'h0000_0941);
        @(negedge clk); irq_in[3] = 1'b1;
        wait_valid("R6 edge delivers");
        check("R6 edge vector", {24'h0, dlv_vector}, 32'h41);
        check("R11 logical dest", {24'h0, dlv_dest}, 32'h5A);
        check("R6 edge mode", {29'h0, dlv_mode}, 32'h1);
        rd_reg(8'h10 + 8'd6, d);
        check("R10 delivery status while held", d, 32'h0000_1941);
        tick(3);
        check("R10 valid held", {31'h0, dlv_valid}, 32'h1);
        check("R10 vector held", {24'h0, dlv_vector}, 32'h41);
        accept();
        tick(5);
        check("R6 held line no redelivery", {31'h0, dlv_valid}, 32'h0);
        rd_reg(8'h10 + 8'd6, d);
        check("R10 delivery status cleared", d, 32'h0000_0941);
        irq_in[3] = 1'b0;
        tick(2);
    endtask

    task automatic t_polarity();
        @(negedge clk); irq_in[6] = 1'b1;
        wr_reg(8'h11 + 8'd12, 32'hF300_0000);
        wr_reg(8'h10 + 8'd12, 32'h0000_2052);
        tick(4);
        check("R6 active-low idle no request", {31'h0, dlv_valid}, 32'h0);
        irq_in[6] = 1'b0;
        wait_valid("R6 active-low edge delivers");
        check("R6 active-low vector", {24'h0, dlv_vector}, 32'h52);
        check("R11 physical dest trimmed", {24'h0, dlv_dest}, 32'h03);
        check("R11 physical mode flag", {31'h0, dlv_dstmode}, 32'h0);
        accept();
        irq_in[6] = 1'b1;
        tick(4);
        check("R6 release no delivery", {31'h0, dlv_valid}, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr_reg(8'h11 + 8'd20, 32'h0100_0000);
        wr_reg(8'h10 + 8'd20, 32'h0000_8063);
        @(negedge clk); irq_in[10] = 1'b1;
        wait_valid("R7 level delivers");
        check("R7 level vector", {24'h0, dlv_vector}, 32'h63);
        accept();
        tick(4);
        check("R7 blocked by irr", {31'h0, dlv_valid}, 32'h0);
        rd_reg(8'h10 + 8'd20, d);
        check("R7 irr visible", d, 32'h0000_C063);
        send_eoi(8'h64);
        tick(3);
        check("R7 wrong eoi no delivery", {31'h0, dlv_valid}, 32'h0);
        rd_reg(8'h10 + 8'd20, d);
        check("R7 wrong eoi keeps irr", d, 32'h0000_C063);
        send_eoi(8'h63);
        wait_valid("R7 matching eoi redelivers");
        check("R7 redelivered vector", {24'h0, dlv_vector}, 32'h63);
        irq_in[10] = 1'b0;
        accept();
        send_eoi(8'h63);
        tick(3);
        rd_reg(8'h10 + 8'd20, d);
        check("R7 irr cleared", d, 32'h0000_8063);
        check("R7 idle after release", {31'h0, dlv_valid}, 32'h0);
    endtask

    task automatic t_mask();
        wr_reg(8'h10 + 8'd24, 32'h0001_0070);
        @(negedge clk); irq_in[12] = 1'b1;
        tick(5);
        check("R8 masked no request", {31'h0, dlv_valid}, 32'h0);
        wr_reg(8'h10 + 8'd24, 32'h0000_0070);
        tick(5);
        check("R8 masked edge discarded", {31'h0, dlv_valid}, 32'h0);
        irq_in[12] = 1'b0;
        tick(2);
        irq_in[12] = 1'b1;
        wait_valid("R8 fresh edge after unmask");
        check("R8 vector after unmask", {24'h0, dlv_vector}, 32'h70);
        accept();
        irq_in[12] = 1'b0;
        tick(2);
    endtask

    task automatic t_priority();
        wr_reg(8'h10 + 8'd40, 32'h0000_0090);
        wr_reg(8'h10 + 8'd30, 32'h0000_0080);
        @(negedge clk); irq_in[20] = 1'b1; irq_in[15] = 1'b1;
        wait_valid("R9 simultaneous delivers");
        tick(2);
        check("R9 lowest line first", {24'h0, dlv_vector}, 32'h80);
        accept();
        check("R9 next line follows", {31'h0, dlv_valid}, 32'h1);
        check("R9 second vector", {24'h0, dlv_vector}, 32'h90);
        accept();
        tick(3);
        check("R9 both drained", {31'h0, dlv_valid}, 32'h0);
        irq_in[20] = 1'b0; irq_in[15] = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_window();
        t_readonly();
        t_edge();
        t_polarity();
        t_level();
        t_mask();
        t_priority();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule